// File: doc/BRIEF.md
# ADC serial readout port

This block is the digital control behind the serial output of a delta-sigma converter. It steps through three phases. In the converting phase a result is being formed. In the sleep phase a finished result waits to be read. In the readout phase a 32-bit frame is shifted out on a three-state data line. An active-low select line wakes the port and opens the data driver. While the port is not in readout, the data line carries a busy/ready flag.

The serial clock pin can run in two ways. The port can drive it as an output from an internal divider, or it can accept a clock from the host. The pin level sampled just after reset, and again at every falling edge of select, decides which way. A frequency-select input sets the conversion timebase: a steady high level, a steady low level, or an external toggling clock. A behavioural stub stands in for the converter. It latches a signed analog word and classifies it as in range, over range or under range.

Top module: `adc_serial_port`

## Requirements
- R1: `sdo_oe` is low whenever `csn_i` is high, and high whenever `csn_i` is low.
- R2: With select low, `sdo_o` reads 1 while a conversion is running and 0 once a result is waiting.
- R3: The serial clock mode is latched from the clock pin level in the first cycle after reset and at each synchronised falling edge of select. A level of 1 selects the internal clock and a level of 0 selects the external clock.
- R4: In internal mode `sck_pullup_en` is 1 and `sck_oe` is 1 during readout. In external mode both are 0.
- R5: When a conversion completes the port enters sleep, and it stays there while select remains high; the waiting result is not replaced.
- R6: Select going low in sleep starts readout. The first bit presented is the ready status (0).
- R7: Select rising during readout abandons the frame and starts a new conversion at once.
- R8: A conversion lasts CONV_TICKS timebase ticks. A tick comes every DIV_HI system clocks when the frequency-select input is steadily high. It comes every DIV_LO clocks when that input is steadily low. It comes on each rising edge when the input toggles.
- R9: The frame is 32 bits, sent MSB first. Bit 31 is status (0), bit 30 is 0, bit 29 is sign, bit 28 is range extension, bits 27..4 are the 24-bit result and bits 3..0 are 0.
- R10: For a signed 26-bit input v in [-2^24, 2^24-1], sign is 1 when v >= 0, extension is 0 and the result is v[23:0]. Above that range the port sends sign 1, extension 1 and result 0. Below it the port sends sign 0, extension 1 and result all ones.
- R11: The data line changes after a falling serial clock edge, so each bit is stable at the following rising edge. The internal clock idles low and toggles every SCK_HALF system clocks.
- R12: After the 32nd falling clock edge of a frame a new conversion starts without select rising, so `sdo_o` reads 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Active-low select |
| sck_i | input | 1 | Level seen on the serial clock pin |
| sck_o | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sck_pullup_en | output | 1 | Enable for a weak pull-up on the clock pin |
| sdo_o | output | 1 | Serial data / status value |
| sdo_oe | output | 1 | Drive enable for the data pin (0 = high impedance) |
| fsel_i | input | 1 | Timebase select: steady high, steady low, or toggling clock |
| ain_i | input | 26 | Signed analog input word for the converter stub |

## Verification
The port can see the last falling clock edge of a frame and a select rise in the same system cycle. That makes end of frame and abort coincide. The bench provokes this by dropping its external clock and raising select on the same edge. Both pass through equal synchronisers. The full frame must still match the scoreboard. The next read must show busy, and the following conversion time must equal one normal conversion, which shows that only one restart happened.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

   typedef enum logic [1:0] {
      PH_CONV  = 2'd0,
      PH_SLEEP = 2'd1,
      PH_DATA  = 2'd2
   } phase_t;

endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] st;

   if (STAGES < 1) begin : g_bad_stages
      $error("adc_sync: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= RST_VAL;
            else        st <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= {STAGES{RST_VAL}};
            else        st <= {st[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/adc_timebase.sv
module adc_timebase #(
   parameter int DIV_HI      = 20,
   parameter int DIV_LO      = 14,
   parameter int WIN         = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fsel_i,
   input  logic restart,
   output logic tick
);
   localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
   localparam int CW   = $clog2(DMAX + 1);
   localparam int WW   = $clog2(WIN + 1);

   if (DIV_HI < 2 || DIV_LO < 2) begin : g_bad_div
      $error("adc_timebase: dividers must be at least 2");
   end
   if (WIN < 4) begin : g_bad_win
      $error("adc_timebase: WIN must be at least 4");
   end

   logic          fs, fprev, ext_clk;
   logic [CW-1:0] cnt, lim;
   logic [WW-1:0] quiet;

   adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_fsync (
      .clk(clk), .rst_n(rst_n), .d(fsel_i), .q(fs));

   assign lim = fs ? CW'(DIV_HI) : CW'(DIV_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fprev   <= 1'b1;
         quiet   <= '0;
         ext_clk <= 1'b0;
      end else begin
         fprev <= fs;
         if (fs != fprev) begin
            quiet   <= '0;
            ext_clk <= 1'b1;
         end else if (quiet == WW'(WIN - 1)) begin
            ext_clk <= 1'b0;
         end else begin
            quiet <= quiet + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (restart || ext_clk)      cnt <= '0;
      else if (cnt >= lim - 1'b1)       cnt <= '0;
      else                              cnt <= cnt + 1'b1;
   end

   assign tick = ext_clk ? (fs & ~fprev)
                         : ((cnt >= lim - 1'b1) & ~restart);
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
   parameter int RES_W      = 24,
   parameter int IN_W       = 26,
   parameter int CONV_TICKS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    tick,
   input  logic signed [IN_W-1:0]  ain,
   output logic                    done,
   output logic                    c_sign,
   output logic                    c_ext,
   output logic [RES_W-1:0]        c_res
);
   localparam int TW = $clog2(CONV_TICKS + 1);
   localparam logic signed [IN_W-1:0] HI_LIM = IN_W'((64'sd1 <<< RES_W) - 1);
   localparam logic signed [IN_W-1:0] LO_LIM = -HI_LIM - 1;

   if (IN_W < RES_W + 2) begin : g_bad_inw
      $error("adc_conv_stub: IN_W must exceed RES_W by at least 2");
   end
   if (CONV_TICKS < 1) begin : g_bad_ticks
      $error("adc_conv_stub: CONV_TICKS must be at least 1");
   end

   logic          busy;
   logic [TW-1:0] tcnt;
   logic          over, under;

   assign over  = ain > HI_LIM;
   assign under = ain < LO_LIM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b1;
         tcnt   <= '0;
         done   <= 1'b0;
         c_sign <= 1'b0;
         c_ext  <= 1'b0;
         c_res  <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            tcnt <= '0;
         end else if (busy && tick) begin
            if (tcnt == TW'(CONV_TICKS - 1)) begin
               busy   <= 1'b0;
               done   <= 1'b1;
               c_sign <= over | (~under & ~ain[IN_W-1]);
               c_ext  <= over | under;
               c_res  <= over ? '0 : (under ? '1 : ain[RES_W-1:0]);
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/adc_sck_unit.sv
module adc_sck_unit #(
   parameter int SCK_HALF    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_fall,
   input  logic run,
   output logic int_mode,
   output logic sck_o,
   output logic sck_fall
);
   localparam int HW = $clog2(SCK_HALF + 1);

   if (SCK_HALF < 2) begin : g_bad_half
      $error("adc_sck_unit: SCK_HALF must be at least 2");
   end

   logic          ss, sprev, boot, sck_q;
   logic [HW-1:0] hcnt;
   logic          int_fall, ext_fall;

   adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ssync (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(ss));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot     <= 1'b1;
         int_mode <= 1'b0;
         sprev    <= 1'b0;
      end else begin
         sprev <= ss;
         boot  <= 1'b0;
         if (boot)         int_mode <= sck_i;
         else if (cs_fall) int_mode <= ss;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt  <= '0;
         sck_q <= 1'b0;
      end else if (!(run && int_mode)) begin
         hcnt  <= '0;
         sck_q <= 1'b0;
      end else if (hcnt == HW'(SCK_HALF - 1)) begin
         hcnt  <= '0;
         sck_q <= ~sck_q;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   assign int_fall = run & int_mode & sck_q & (hcnt == HW'(SCK_HALF - 1));
   assign ext_fall = run & ~int_mode & sprev & ~ss;
   assign sck_fall = int_mode ? int_fall : ext_fall;
   assign sck_o    = sck_q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
   import adc_port_pkg::*;
#(
   parameter int RES_W       = 24,
   parameter int PAD_W       = 4,
   parameter int IN_W        = 26,
   parameter int CONV_TICKS  = 8,
   parameter int DIV_HI      = 20,
   parameter int DIV_LO      = 14,
   parameter int FSEL_WIN    = 64,
   parameter int SCK_HALF    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   csn_i,
   input  logic                   sck_i,
   output logic                   sck_o,
   output logic                   sck_oe,
   output logic                   sck_pullup_en,
   output logic                   sdo_o,
   output logic                   sdo_oe,
   input  logic                   fsel_i,
   input  logic signed [IN_W-1:0] ain_i
);
   localparam int FRAME_W = 4 + RES_W + PAD_W;
   localparam int BC_W    = $clog2(FRAME_W + 1);

   if (PAD_W < 1) begin : g_bad_pad
      $error("adc_serial_port: PAD_W must be at least 1");
   end

   phase_t             phase;
   logic               csn_s, cs_prev, cs_fall, cs_rise;
   logic               int_mode, sck_fall, conv_start, tick, done;
   logic               c_sign, c_ext;
   logic [RES_W-1:0]   c_res;
   logic [FRAME_W-1:0] shreg;
   logic [BC_W-1:0]    bcnt;
   logic               last_bit;

   adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csync (
      .clk(clk), .rst_n(rst_n), .d(csn_i), .q(csn_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_prev <= 1'b1;
      else        cs_prev <= csn_s;
   end
   assign cs_fall = cs_prev & ~csn_s;
   assign cs_rise = ~cs_prev & csn_s;

   adc_sck_unit #(.SCK_HALF(SCK_HALF), .SYNC_STAGES(SYNC_STAGES)) u_sck (
      .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .cs_fall(cs_fall),
      .run(phase == PH_DATA), .int_mode(int_mode), .sck_o(sck_o),
      .sck_fall(sck_fall));

   adc_timebase #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO), .WIN(FSEL_WIN),
                  .SYNC_STAGES(SYNC_STAGES)) u_tb (
      .clk(clk), .rst_n(rst_n), .fsel_i(fsel_i), .restart(conv_start),
      .tick(tick));

   adc_conv_stub #(.RES_W(RES_W), .IN_W(IN_W), .CONV_TICKS(CONV_TICKS)) u_conv (
      .clk(clk), .rst_n(rst_n), .start(conv_start), .tick(tick), .ain(ain_i),
      .done(done), .c_sign(c_sign), .c_ext(c_ext), .c_res(c_res));

   assign last_bit   = (bcnt == BC_W'(FRAME_W - 1));
   assign conv_start = (phase == PH_DATA) & (cs_rise | (sck_fall & last_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_CONV;
         shreg <= '0;
         bcnt  <= '0;
      end else begin
         case (phase)
            PH_CONV: begin
               if (done) phase <= PH_SLEEP;
            end
            PH_SLEEP: begin
               if (!csn_s) begin
                  phase <= PH_DATA;
                  shreg <= {2'b00, c_sign, c_ext, c_res, {PAD_W{1'b0}}};
                  bcnt  <= '0;
               end
            end
            PH_DATA: begin
               if (conv_start) begin
                  phase <= PH_CONV;
               end else if (sck_fall) begin
                  shreg <= {shreg[FRAME_W-2:0], 1'b0};
                  bcnt  <= bcnt + 1'b1;
               end
            end
            default: phase <= PH_CONV;
         endcase
      end
   end

   assign sdo_o         = (phase == PH_DATA) ? shreg[FRAME_W-1] : (phase == PH_CONV);
   assign sdo_oe        = ~csn_i;
   assign sck_oe        = int_mode & (phase == PH_DATA);
   assign sck_pullup_en = int_mode;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
   parameter int FRAME_W = 32,
   parameter int BC_W    = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            csn_i,
   input logic            csn_s,
   input logic            cs_rise,
   input logic [1:0]      phase,
   input logic            sck_fall,
   input logic [BC_W-1:0] bcnt,
   input logic            done,
   input logic            sck_oe,
   input logic            sck_pullup_en,
   input logic            sdo_oe
);
   localparam logic [1:0] P_CONV  = 2'd0;
   localparam logic [1:0] P_SLEEP = 2'd1;
   localparam logic [1:0] P_DATA  = 2'd2;

   a_r1_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      csn_i |-> !sdo_oe);

   a_r4_drive_needs_pullup: assert property (@(posedge clk) disable iff (!rst_n)
      sck_oe |-> sck_pullup_en);

   a_r5_done_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_CONV && done) |=> phase == P_SLEEP);

   a_r5_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_SLEEP && csn_s) |=> phase == P_SLEEP);

   a_r6_wake_to_data: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_SLEEP && !csn_s) |=> phase == P_DATA);

   a_r7_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_DATA && cs_rise) |=> phase == P_CONV);

   a_r12_frame_end_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_DATA && sck_fall && bcnt == BC_W'(FRAME_W - 1)) |=> phase == P_CONV);
endmodule

bind adc_serial_port adc_serial_port_chk #(.FRAME_W(FRAME_W), .BC_W(BC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .csn_s(csn_s), .cs_rise(cs_rise),
   .phase(phase), .sck_fall(sck_fall), .bcnt(bcnt), .done(done),
   .sck_oe(sck_oe), .sck_pullup_en(sck_pullup_en), .sdo_oe(sdo_oe));

// File: tb/tb_adc_serial_port.sv
`timescale 1ns/1ps
module tb_adc_serial_port;
   logic clk = 1'b0;
   logic rst_n, csn, ext_sck, fsel, fsel_tog;
   logic signed [25:0] ain;
   logic sck_o, sck_oe, sck_pullup_en, sdo_o, sdo_oe, sck_pin;

   always #2.5 clk = ~clk;

   assign sck_pin = sck_oe ? sck_o : ext_sck;

   adc_serial_port dut (
      .clk(clk), .rst_n(rst_n), .csn_i(csn), .sck_i(sck_pin), .sck_o(sck_o),
      .sck_oe(sck_oe), .sck_pullup_en(sck_pullup_en), .sdo_o(sdo_o),
      .sdo_oe(sdo_oe), .fsel_i(fsel), .ain_i(ain));

   int checks = 0, errors = 0;
   logic [31:0] exp_q[$];
   bit  mon_on = 0;
   int  mon_bits = 0, frames_done = 0;
   logic [31:0] mon_word;
   realtime last_fall_t;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int v, input int lo, input int hi);
      checks++;
      if (v < lo || v > hi) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, v, lo, hi);
      end
   endtask

   // R9 / R10 frame model
   function automatic logic [31:0] exp_frame(input logic signed [25:0] v);
      if (v > 26'sd16777215)       return {4'b0011, 24'h000000, 4'h0};
      else if (v < -26'sd16777216) return {4'b0001, 24'hFFFFFF, 4'h0};
      else                         return {2'b00, ~v[25], 1'b0, v[23:0], 4'h0};
   endfunction

   // monitor: samples on each rising pin edge (R11), compares frames (R9, R10)
   always @(posedge sck_pin) begin
      if (mon_on) begin
         #1;
         mon_word = {mon_word[30:0], sdo_o};
         mon_bits++;
         if (mon_bits == 32) begin
            mon_on = 0;
            mon_bits = 0;
            frames_done++;
            if (exp_q.size() == 0) chk("R9 unexpected frame", mon_word, 32'hx);
            else chk("R9/R10/R11 frame", mon_word, exp_q.pop_front());
         end
      end
   end

   always begin
      @(negedge clk);
      if (fsel_tog) begin
         fsel = ~fsel;
         repeat (4) @(negedge clk);
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ext_frame(input logic [31:0] expw, input int nbits, input bit last_cs_rise);
      exp_q.push_back(expw);
      mon_bits = 0;
      mon_on = 1;
      for (int i = 0; i < nbits; i++) begin
         ext_sck = 1'b1;
         wait_clk(10);
         ext_sck = 1'b0;
         if (last_cs_rise && i == nbits - 1) csn = 1'b1;
         last_fall_t = $realtime;
         wait_clk(10);
      end
   endtask

   task automatic wait_ready(output int cyc);
      int n = 0;
      while (!(sdo_oe === 1'b1 && sdo_o === 1'b0) && n < 3000) begin
         @(negedge clk);
         n++;
      end
      cyc = int'(($realtime - last_fall_t) / 5.0);
   endtask

   initial begin
      int cyc, fd;
      rst_n = 0; csn = 1; ext_sck = 0; fsel = 1; fsel_tog = 0; ain = 26'sd1000;
      wait_clk(5);
      rst_n = 1;
      wait_clk(3);
      chk("R1 reset hiz", {31'b0, sdo_oe}, 32'd0);
      chk("R4 reset pullup ext", {31'b0, sck_pullup_en}, 32'd0);
      chk("R4 reset no drive", {31'b0, sck_oe}, 32'd0);

      wait_clk(400);
      chk("R1 sleep hiz", {31'b0, sdo_oe}, 32'd0);
      csn = 0;
      wait_clk(6);
      chk("R6 data enabled", {31'b0, sdo_oe}, 32'd1);
      chk("R2/R5 ready status", {31'b0, sdo_o}, 32'd0);
      ain = -26'sd5000;
      ext_frame(exp_frame(26'sd1000), 32, 0);
      wait_clk(4);
      chk("R12 busy after frame", {31'b0, sdo_o}, 32'd1);
      wait_ready(cyc);
      chk_rng("R8 timebase high", cyc, 160, 175);

      fsel = 0;
      wait_clk(4);
      ext_frame(exp_frame(-26'sd5000), 32, 0);
      ain = 26'sd16777223;
      wait_clk(4);
      chk("R12 busy after frame 2", {31'b0, sdo_o}, 32'd1);
      wait_ready(cyc);
      chk_rng("R8 timebase low", cyc, 112, 127);

      fsel_tog = 1;
      wait_clk(30);
      ext_frame(exp_frame(26'sd16777223), 32, 0);
      ain = -26'sd16777219;
      wait_ready(cyc);
      chk_rng("R8 toggling timebase", cyc, 70, 105);
      fsel_tog = 0;
      wait_clk(2);
      fsel = 1;
      ext_frame(exp_frame(-26'sd16777219), 32, 0);
      ain = 26'sd123;
      wait_clk(150);
      wait_ready(cyc);

      // R7 abort after 5 bits
      ext_frame(32'h0, 5, 0);
      csn = 1;
      mon_on = 0; mon_bits = 0;
      void'(exp_q.pop_back());
      wait_clk(6);
      csn = 0;
      wait_clk(6);
      chk("R7 abort restarts conversion", {31'b0, sdo_o}, 32'd1);
      wait_ready(cyc);
      ext_frame(exp_frame(26'sd123), 32, 0);
      ain = 26'sd77;
      wait_ready(cyc);

      // frame end and select rise on the same edge
      ext_frame(exp_frame(26'sd77), 32, 1);
      wait_clk(6);
      csn = 0;
      wait_clk(6);
      chk("R7/R12 coincident restart busy", {31'b0, sdo_o}, 32'd1);
      wait_ready(cyc);
      chk_rng("R12 single restart time", cyc, 160, 175);
      ain = -26'sd1;
      ext_frame(exp_frame(26'sd77), 32, 0);
      void'(exp_q.pop_back());
      mon_on = 0;

      // R3 internal mode via pull-up level at select fall
      csn = 1; ext_sck = 1;
      wait_clk(300);
      exp_q.push_back(exp_frame(-26'sd1));
      mon_bits = 0; mon_on = 1;
      fd = frames_done;
      csn = 0;
      wait_clk(6);
      chk("R3/R4 internal pullup", {31'b0, sck_pullup_en}, 32'd1);
      wait_clk(20);
      chk("R4 internal drives clock", {31'b0, sck_oe}, 32'd1);
      for (int i = 0; i < 1000 && frames_done == fd; i++) @(negedge clk);
      chk("R11 internal frame seen", frames_done, fd + 1);
      wait_clk(4);
      chk("R4 drive off after readout", {31'b0, sck_oe}, 32'd0);
      chk("R12 busy after internal frame", {31'b0, sdo_o}, 32'd1);

      csn = 1; ext_sck = 0;
      wait_clk(6);
      csn = 0;
      wait_clk(6);
      chk("R3 back to external", {31'b0, sck_pullup_en}, 32'd0);
      csn = 1;
      wait_clk(3);
      chk("R1 hiz after deselect", {31'b0, sdo_oe}, 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule